// File: doc/BRIEF.md
# Paged program memory address mapper

This block sits between a 16-bit CPU address bus and the external memories of a microcontroller running in expanded mode. It turns each CPU address into a physical program-memory page number and a 14-bit offset inside that page. It also raises one select each for external program Flash, the internal 4K EEPROM and external data RAM. Startup code uses a small write port to load a page register and a control register. The address mapping itself has no clock and follows the current register state at once.

CPU addresses 0x8000–0xBFFF form a 16K window. While paging is on, that window shows whichever Flash page the page register names. Addresses 0xC000–0xFFFF always show the last Flash page. Out of reset, paging is off and every high-order page line is driven high, so the window shows the second-last page. Init code should therefore run from the fixed upper range. When the EEPROM is switched on, it claims 0xF000–0xFFFF, and the Flash beneath it can then be reached only through the window. No data stream passes through this block, so it has no valid/ready handshake. All pins are plain control and address signals.

Top module: `pgmap_top`

## Requirements
- R1: After reset the page register holds 0 and the control register holds 4'b0110. In that value, bit 0 is the window enable (0), bit 1 is the EEPROM enable (1), bit 2 is the program select enable (1) and bit 3 is the data select enable (0).
- R2: A write with `wr_en` high and `wr_reg`=0 loads the page register from `wr_data`. With `wr_reg`=1, `wr_data[3:0]` loads the control register. The new value changes the outputs only after the next rising clock edge.
- R3: While the window is disabled, `phys_page` equals all ones in bits PG_W-1..2, with bits 1..0 taken from CPU address bits 15..14. `phys_ofs` always equals CPU address bits 13..0.
- R4: While the window is enabled, CPU addresses 0x8000–0xBFFF give `phys_page` = the page register.
- R5: CPU addresses 0xC000–0xFFFF always give `phys_page` = the last page (all ones), whatever the window enable.
- R6: Page-register bits at position PG_W and above are ignored when the physical page is formed.
- R7: While the EEPROM is enabled, CPU addresses 0xF000–0xFFFF assert `ee_sel` and never `prog_sel`.
- R8: `prog_sel` is high only when the program select enable is set, CPU address bit 15 is 1, and the address is not claimed by the EEPROM.
- R9: `data_sel` is high only when the data select enable is set and CPU address bit 15 is 0. When the parameter A19_GATE is 1, `data_a19` must also be high.
- R10: At most one of `prog_sel`, `ee_sel` and `data_sel` is high at a time. An address below 0x8000 that data RAM does not claim asserts none of them.
- R11: The parameter BIG_DEV sets the device size: 0 gives a 128K device (PG_W = 3, last page 0x07), and 1 gives a 512K device (PG_W = 5, last page 0x1F).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register write port |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_reg | input | 1 | 0 = page register, 1 = control register |
| wr_data | input | DW (8) | Write data |
| cpu_addr | input | 16 | CPU address |
| data_a19 | input | 1 | Address line A19 used by the data RAM gating option |
| phys_page | output | PG_W (5) | Physical page; bits PG_W-1..2 are the high-order lines A16 and up |
| phys_ofs | output | 14 | Offset within the 16K page |
| prog_sel | output | 1 | External program Flash select |
| ee_sel | output | 1 | Internal EEPROM select |
| data_sel | output | 1 | External data RAM select |

## Verification
On every cycle the assertions check four things: the selects stay mutually exclusive, the EEPROM hides Flash in the top 4K, the fixed upper range lands on the last page, and the page lines stay high while paging is off. They also check that a register write shows up one edge later. Other behaviours need the bench's scenarios. These are the aliasing to the second-last page out of reset, the jump to page 0 when paging is first switched on, the discarding of excess page bits, the A19 gating of data RAM, and the edge values 0x7FFF, 0xBFFF, 0xC000, 0xEFFF and 0xF000.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  typedef struct packed {
    logic data_cs_en;
    logic prog_cs_en;
    logic ee_en;
    logic win_en;
  } pgmap_ctrl_t;

  localparam logic [3:0] CTRL_RST = 4'b0110;

  function automatic int pg_width(input int big_dev);
    return (big_dev != 0) ? 5 : 3;
  endfunction
endpackage

// File: rtl/pgmap_regs.sv
module pgmap_regs #(
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_reg,
  input  logic [DW-1:0]          wr_data,
  output logic [DW-1:0]          page_q,
  output pgmap_pkg::pgmap_ctrl_t ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ctrl_q <= pgmap_pkg::CTRL_RST;
    end else if (wr_en) begin
      if (wr_reg) ctrl_q <= wr_data[3:0];
      else        page_q <= wr_data;
    end
  end

  // R2
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_reg) |=> (page_q == $past(wr_data)));

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_reg) |=> (ctrl_q == $past(wr_data[3:0])));
endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate #(
  parameter int DW   = 8,
  parameter int PG_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_en,
  input  logic [DW-1:0]   page_q,
  input  logic [15:0]     cpu_addr,
  output logic [PG_W-1:0] phys_page,
  output logic [13:0]     phys_ofs
);
  localparam int HI_W = PG_W - 2;
  localparam logic [PG_W-1:0] LAST_PG = '1;

  logic in_fixed, in_window;
  assign in_fixed  = cpu_addr[15] & cpu_addr[14];
  assign in_window = cpu_addr[15] & ~cpu_addr[14];

  always_comb begin
    phys_ofs = cpu_addr[13:0];
    if (in_fixed)
      phys_page = LAST_PG;
    else if (win_en && in_window)
      phys_page = page_q[PG_W-1:0];
    else
      phys_page = {{HI_W{1'b1}}, cpu_addr[15:14]};
  end

  // R5
  fixed_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b11) |-> (&phys_page));

  // R3
  unpaged_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> ((&phys_page[PG_W-1:2]) && phys_page[1:0] == cpu_addr[15:14]));
endmodule

// File: rtl/pgmap_decode.sv
module pgmap_decode #(
  parameter bit A19_GATE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  pgmap_pkg::pgmap_ctrl_t ctrl,
  input  logic [15:0]            cpu_addr,
  input  logic                   data_a19,
  output logic                   prog_sel,
  output logic                   ee_sel,
  output logic                   data_sel
);
  logic top4k, a19_ok;
  assign top4k = (cpu_addr[15:12] == 4'hF);

  generate
    if (A19_GATE) begin : g_gate
      assign a19_ok = data_a19;
    end else begin : g_nogate
      assign a19_ok = 1'b1;
    end
  endgenerate

  assign ee_sel   = ctrl.ee_en & top4k;
  assign prog_sel = ctrl.prog_cs_en & cpu_addr[15] & ~ee_sel;
  assign data_sel = ctrl.data_cs_en & ~cpu_addr[15] & a19_ok;

  // R10
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_sel, ee_sel, data_sel}));

  // R7
  ee_hides_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sel |-> !prog_sel);

  // R8
  prog_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_sel |-> (cpu_addr[15] && ctrl.prog_cs_en));
endmodule

// File: rtl/pgmap_top.sv
module pgmap_top #(
  parameter int DW       = 8,
  parameter bit BIG_DEV  = 1'b1,
  parameter bit A19_GATE = 1'b1,
  localparam int PG_W    = pgmap_pkg::pg_width(int'(BIG_DEV))
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_reg,
  input  logic [DW-1:0]   wr_data,
  input  logic [15:0]     cpu_addr,
  input  logic            data_a19,
  output logic [PG_W-1:0] phys_page,
  output logic [13:0]     phys_ofs,
  output logic            prog_sel,
  output logic            ee_sel,
  output logic            data_sel
);
  logic [DW-1:0]          page_q;
  pgmap_pkg::pgmap_ctrl_t ctrl_q;

  pgmap_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg),
    .wr_data(wr_data), .page_q(page_q), .ctrl_q(ctrl_q)
  );

  pgmap_xlate #(.DW(DW), .PG_W(PG_W)) u_xlate (
    .clk(clk), .rst_n(rst_n), .win_en(ctrl_q.win_en), .page_q(page_q),
    .cpu_addr(cpu_addr), .phys_page(phys_page), .phys_ofs(phys_ofs)
  );

  pgmap_decode #(.A19_GATE(A19_GATE)) u_dec (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .cpu_addr(cpu_addr),
    .data_a19(data_a19), .prog_sel(prog_sel), .ee_sel(ee_sel),
    .data_sel(data_sel)
  );

  // R11
  initial pg_width_chk: assert (PG_W == (BIG_DEV ? 5 : 3));
endmodule

// File: tb/pgmap_top_test.sv
module pgmap_top_test;
  localparam int PG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_reg = 1'b0, data_a19 = 1'b0;
  logic [7:0] wr_data = '0;
  logic [15:0] cpu_addr = '0;
  logic [PG_W-1:0] phys_page;
  logic [13:0] phys_ofs;
  logic prog_sel, ee_sel, data_sel;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // bench-side copy of register state, derived from R1/R2
  logic [7:0] m_page;
  logic [3:0] m_ctrl;

  always #2 clk = ~clk;

  pgmap_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg),
    .wr_data(wr_data), .cpu_addr(cpu_addr), .data_a19(data_a19),
    .phys_page(phys_page), .phys_ofs(phys_ofs), .prog_sel(prog_sel),
    .ee_sel(ee_sel), .data_sel(data_sel)
  );

  function automatic logic [PG_W-1:0] exp_page(input logic [15:0] a,
      input logic [7:0] pg, input logic [3:0] c);
    if (a[15:14] == 2'b11) return '1;
    if (c[0] && a[15:14] == 2'b10) return pg[PG_W-1:0];
    return {3'b111, a[15:14]};
  endfunction

  function automatic logic [2:0] exp_sel(input logic [15:0] a,
      input logic a19, input logic [3:0] c);
    logic ee, pr, da;
    ee = c[1] && a[15:12] == 4'hF;
    pr = c[2] && a[15] && !ee;
    da = c[3] && !a[15] && a19;
    return {pr, ee, da};
  endfunction

  task automatic cmp(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic r, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_reg = r; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    if (r) m_ctrl = d[3:0]; else m_page = d;
  endtask

  task automatic probe(input string req, input logic [15:0] a, input logic a19);
    @(negedge clk);
    cpu_addr = a; data_a19 = a19;
    #1;
    cmp({req, " page"}, 32'(phys_page), 32'(exp_page(a, m_page, m_ctrl)));
    cmp({req, " ofs"}, 32'(phys_ofs), 32'(a[13:0]));
    cmp({req, " sel"}, 32'({prog_sel, ee_sel, data_sel}), 32'(exp_sel(a, a19, m_ctrl)));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_page = 8'h00; m_ctrl = 4'b0110;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 / R3: reset aliasing to second-last page, program select on
    probe("R1", 16'h8000, 1'b1);
    cmp("R1 aliased page", 32'(phys_page), 32'h1E);
    cmp("R8 reset prog_sel", 32'(prog_sel), 32'd1);
    probe("R3", 16'hBFFF, 1'b1);
    probe("R5", 16'hC000, 1'b0);
    cmp("R5 last page", 32'(phys_page), 32'h1F);
    probe("R7", 16'hF000, 1'b0);
    cmp("R7 ee_sel", 32'(ee_sel), 32'd1);
    cmp("R7 prog hidden", 32'(prog_sel), 32'd0);
    probe("R8", 16'hEFFF, 1'b0);
    cmp("R8 prog below ee", 32'(prog_sel), 32'd1);
    probe("R10", 16'h1234, 1'b1);
    cmp("R10 no select low", 32'({prog_sel, ee_sel, data_sel}), 32'd0);

    // R2: write is invisible before the edge, visible after
    @(negedge clk);
    cpu_addr = 16'h8000; wr_en = 1'b1; wr_reg = 1'b1; wr_data = 8'h07;
    #1 cmp("R2 before edge", 32'(phys_page), 32'h1E);
    @(posedge clk);
    #1 wr_en = 1'b0; m_ctrl = 4'h7;
    cmp("R2 after edge", 32'(phys_page), 32'h00);
    cmp("R4 page zero on enable", 32'(phys_page), 32'(m_page[PG_W-1:0]));

    // R4 / R6: paging, excess page bits discarded
    wr(1'b0, 8'h0B);
    probe("R4", 16'h9ABC, 1'b0);
    cmp("R4 page", 32'(phys_page), 32'h0B);
    wr(1'b0, 8'hE3);
    probe("R6", 16'h8001, 1'b0);
    cmp("R6 masked", 32'(phys_page), 32'h03);
    probe("R5", 16'hC000, 1'b0);
    probe("R10", 16'h7FFF, 1'b1);

    // R9: data select with A19 gating
    wr(1'b1, 8'h0F);
    probe("R9", 16'h2000, 1'b0);
    cmp("R9 a19 low", 32'(data_sel), 32'd0);
    probe("R9", 16'h2000, 1'b1);
    cmp("R9 a19 high", 32'(data_sel), 32'd1);
    probe("R9", 16'h8000, 1'b1);
    cmp("R9 upper no data", 32'(data_sel), 32'd0);

    // R7 off: EEPROM disabled gives flash at top
    wr(1'b1, 8'h05);
    probe("R7", 16'hFFFF, 1'b0);
    cmp("R7 ee off prog", 32'(prog_sel), 32'd1);
    // R8 off: program select disabled
    wr(1'b1, 8'h0B);
    probe("R8", 16'hA000, 1'b1);
    cmp("R8 disabled", 32'(prog_sel), 32'd0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 4) == 0)
        wr(1'($urandom % 2), 8'($urandom));
      probe("R3-R10 random", 16'($urandom), 1'($urandom % 2));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule